// File: doc/BRIEF.md
# Mailbox Doorbell Interrupt Controller

This block sits beside a two-port memory and watches the access strobes of both ports, called left and right. It reserves the two highest locations of the address space as doorbells. The very top word is the right port's mailbox, and the word just below it is the left port's mailbox. A port rings its peer by writing into the peer's mailbox. That pulls the peer's active-low interrupt output low. The owner acknowledges the interrupt by reading its own mailbox, which returns the output high. The message data itself stays in the memory array; this block only produces the two flags.

Each port has a busy input coming from the memory's collision arbitration. While a port's busy input is high, that port can neither ring its peer nor acknowledge its own interrupt. All strobes are sampled on the rising clock edge, and a flag changes on the edge that samples the qualifying access.

Top module: `mbx_doorbell_top`

## Requirements
- R1: While `rstN` is low, and on the first cycle after reset, `leftIrqN` and `rightIrqN` are both 1 (no interrupt pending).
- R2: A left access with `leftEn`=1, `leftWr`=1, `leftBusy`=0 and `leftAddr` equal to all ones (the right mailbox) drives `rightIrqN` to 0 after the sampling clock edge.
- R3: A right access with `rightEn`=1, `rightWr`=1, `rightBusy`=0 and `rightAddr` equal to all ones minus one (the left mailbox) drives `leftIrqN` to 0 after the sampling edge.
- R4: A read (`En`=1, `Rd`=1, `Wr`=0, busy 0) by a port of its own mailbox returns that port's interrupt output to 1 after the sampling edge.
- R5: A port reading the peer's mailbox, or writing its own mailbox, changes neither interrupt output.
- R6: While a port's busy input is 1, its write to the peer's mailbox leaves the peer's interrupt output unchanged.
- R7: While a port's busy input is 1, its read of its own mailbox leaves its own interrupt output unchanged.
- R8: When a set and a clear of the same flag are sampled on the same edge, the flag ends up asserted (output 0).
- R9: Accesses with the port enable at 0, and accesses to any address other than the two mailboxes, change neither output.
- R10: An access with both `Rd` and `Wr` at 1 counts only as a write; it never acknowledges an interrupt.
- R11: The address width is the parameter `ADDR_W` (16 or 17). The mailboxes are at the top two addresses of that range, so with 17 bits a write to 0x0FFFF rings nothing and a write to 0x1FFFF rings the right port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all strobes sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| leftEn | input | 1 | Left port access enable, active high |
| leftWr | input | 1 | Left port write strobe |
| leftRd | input | 1 | Left port read strobe |
| leftAddr | input | ADDR_W | Left port address |
| leftBusy | input | 1 | Left port busy from arbitration, active high |
| rightEn | input | 1 | Right port access enable, active high |
| rightWr | input | 1 | Right port write strobe |
| rightRd | input | 1 | Right port read strobe |
| rightAddr | input | ADDR_W | Right port address |
| rightBusy | input | 1 | Right port busy from arbitration, active high |
| leftIrqN | output | 1 | Left port interrupt, active low |
| rightIrqN | output | 1 | Right port interrupt, active low |

## Verification
The bound checker watches every cycle. It checks that a qualified, non-busy doorbell write always leaves the peer's flag asserted on the next cycle, and that a qualified own-mailbox read with no competing set always releases the flag. It also checks the converse: a flag only falls after a qualifying peer write, and it only rises after a qualifying own read. Those converse checks cover the busy blocking, the ignored addresses and the write-wins rule for combined strobes. The bench scenarios show what the checker cannot state in general. They cover the reset value, the ordering of a full ring-and-acknowledge exchange on each side, the same-edge set-versus-clear case, and the relocation of the mailboxes when the address width is 17.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Port indices used across control and datapath
  localparam int PORT_LEFT  = 0;
  localparam int PORT_RIGHT = 1;
  localparam int NUM_PORTS  = 2;

  // Strobes from control to datapath, indexed by the flag's owning port
  typedef struct packed {
    logic [NUM_PORTS-1:0] setIrq;
    logic [NUM_PORTS-1:0] clrIrq;
  } flagStrobes_t;

endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] OWN_BOX  = '1,
  parameter logic [ADDR_W-1:0] PEER_BOX = '1
) (
  input  logic              en,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  output logic              ringPeer,
  output logic              ackOwn
);

  logic granted;
  logic isWrite;
  logic isRead;

  always_comb begin
    granted  = en && !busy;
    isWrite  = granted && wr;
    // a combined read+write strobe is treated as a write only
    isRead   = granted && rd && !wr;
    ringPeer = isWrite && (addr == PEER_BOX);
    ackOwn   = isRead && (addr == OWN_BOX);
  end

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl #(
  parameter int ADDR_W = 16
) (
  input  logic [mbx_pkg::NUM_PORTS-1:0] portEn,
  input  logic [mbx_pkg::NUM_PORTS-1:0] portWr,
  input  logic [mbx_pkg::NUM_PORTS-1:0] portRd,
  input  logic [mbx_pkg::NUM_PORTS-1:0] portBusy,
  input  logic [ADDR_W-1:0]             portAddr [mbx_pkg::NUM_PORTS],
  output mbx_pkg::flagStrobes_t         strobes
);

  localparam logic [ADDR_W-1:0] RIGHT_BOX = '1;
  localparam logic [ADDR_W-1:0] LEFT_BOX  = RIGHT_BOX - 1'b1;

  logic [mbx_pkg::NUM_PORTS-1:0] ring;
  logic [mbx_pkg::NUM_PORTS-1:0] ack;

  for (genvar p = 0; p < mbx_pkg::NUM_PORTS; p++) begin : g_port
    localparam logic [ADDR_W-1:0] OWN  = (p == mbx_pkg::PORT_RIGHT) ? RIGHT_BOX : LEFT_BOX;
    localparam logic [ADDR_W-1:0] PEER = (p == mbx_pkg::PORT_RIGHT) ? LEFT_BOX  : RIGHT_BOX;

    mbx_port_dec #(
      .ADDR_W  (ADDR_W),
      .OWN_BOX (OWN),
      .PEER_BOX(PEER)
    ) u_dec (
      .en      (portEn[p]),
      .wr      (portWr[p]),
      .rd      (portRd[p]),
      .addr    (portAddr[p]),
      .busy    (portBusy[p]),
      .ringPeer(ring[p]),
      .ackOwn  (ack[p])
    );

    // a ring from port p raises the flag owned by the other port
    assign strobes.setIrq[mbx_pkg::NUM_PORTS-1-p] = ring[p];
    assign strobes.clrIrq[p]                      = ack[p];
  end

endmodule

// File: rtl/mbx_flags.sv
module mbx_flags (
  input  logic                          clk,
  input  logic                          rstN,
  input  mbx_pkg::flagStrobes_t         strobes,
  output logic [mbx_pkg::NUM_PORTS-1:0] irqN
);

  for (genvar p = 0; p < mbx_pkg::NUM_PORTS; p++) begin : g_flag
    logic pending;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pending <= 1'b0;
      end else if (strobes.setIrq[p]) begin
        // set wins over a same-edge clear so a message is never dropped
        pending <= 1'b1;
      end else if (strobes.clrIrq[p]) begin
        pending <= 1'b0;
      end
    end

    assign irqN[p] = !pending;
  end

endmodule

// File: rtl/mbx_doorbell_top.sv
module mbx_doorbell_top #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              leftEn,
  input  logic              leftWr,
  input  logic              leftRd,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              leftBusy,
  input  logic              rightEn,
  input  logic              rightWr,
  input  logic              rightRd,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              rightBusy,
  output logic              leftIrqN,
  output logic              rightIrqN
);

  logic [mbx_pkg::NUM_PORTS-1:0] portEn;
  logic [mbx_pkg::NUM_PORTS-1:0] portWr;
  logic [mbx_pkg::NUM_PORTS-1:0] portRd;
  logic [mbx_pkg::NUM_PORTS-1:0] portBusy;
  logic [ADDR_W-1:0]             portAddr [mbx_pkg::NUM_PORTS];
  logic [mbx_pkg::NUM_PORTS-1:0] irqN;
  mbx_pkg::flagStrobes_t         strobes;

  assign portEn   = {rightEn, leftEn};
  assign portWr   = {rightWr, leftWr};
  assign portRd   = {rightRd, leftRd};
  assign portBusy = {rightBusy, leftBusy};
  assign portAddr[mbx_pkg::PORT_LEFT]  = leftAddr;
  assign portAddr[mbx_pkg::PORT_RIGHT] = rightAddr;

  mbx_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .portEn  (portEn),
    .portWr  (portWr),
    .portRd  (portRd),
    .portBusy(portBusy),
    .portAddr(portAddr),
    .strobes (strobes)
  );

  mbx_flags u_flags (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .irqN   (irqN)
  );

  assign leftIrqN  = irqN[mbx_pkg::PORT_LEFT];
  assign rightIrqN = irqN[mbx_pkg::PORT_RIGHT];

endmodule

// File: rtl/mbx_doorbell_chk.sv
module mbx_doorbell_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              leftEn,
  input logic              leftWr,
  input logic              leftRd,
  input logic [ADDR_W-1:0] leftAddr,
  input logic              leftBusy,
  input logic              rightEn,
  input logic              rightWr,
  input logic              rightRd,
  input logic [ADDR_W-1:0] rightAddr,
  input logic              rightBusy,
  input logic              leftIrqN,
  input logic              rightIrqN
);

  localparam logic [ADDR_W-1:0] RBOX = '1;
  localparam logic [ADDR_W-1:0] LBOX = RBOX - 1'b1;

  logic ringRight, ringLeft, ackRight, ackLeft;
  assign ringRight = leftEn && leftWr && !leftBusy && (leftAddr == RBOX);
  assign ringLeft  = rightEn && rightWr && !rightBusy && (rightAddr == LBOX);
  assign ackRight  = rightEn && rightRd && !rightWr && !rightBusy && (rightAddr == RBOX);
  assign ackLeft   = leftEn && leftRd && !leftWr && !leftBusy && (leftAddr == LBOX);

  // R2, R8: a doorbell write always leaves the right flag asserted
  a_r2_ring_right: assert property (@(posedge clk) disable iff (!rstN)
    ringRight |=> !rightIrqN);

  // R3, R8: a doorbell write always leaves the left flag asserted
  a_r3_ring_left: assert property (@(posedge clk) disable iff (!rstN)
    ringLeft |=> !leftIrqN);

  // R4: own read with no competing set releases the flag
  a_r4_ack_right: assert property (@(posedge clk) disable iff (!rstN)
    (ackRight && !ringRight) |=> rightIrqN);
  a_r4_ack_left: assert property (@(posedge clk) disable iff (!rstN)
    (ackLeft && !ringLeft) |=> leftIrqN);

  // R6, R9: a flag only falls after a qualifying peer write
  a_r6_right_set_only_by_ring: assert property (@(posedge clk) disable iff (!rstN)
    (rightIrqN && !ringRight) |=> rightIrqN);
  a_r6_left_set_only_by_ring: assert property (@(posedge clk) disable iff (!rstN)
    (leftIrqN && !ringLeft) |=> leftIrqN);

  // R7, R10, R5: a flag only rises after a qualifying own read
  a_r7_right_clear_only_by_ack: assert property (@(posedge clk) disable iff (!rstN)
    (!rightIrqN && !ackRight) |=> !rightIrqN);
  a_r7_left_clear_only_by_ack: assert property (@(posedge clk) disable iff (!rstN)
    (!leftIrqN && !ackLeft) |=> !leftIrqN);

endmodule

bind mbx_doorbell_top mbx_doorbell_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .leftEn   (leftEn),
  .leftWr   (leftWr),
  .leftRd   (leftRd),
  .leftAddr (leftAddr),
  .leftBusy (leftBusy),
  .rightEn  (rightEn),
  .rightWr  (rightWr),
  .rightRd  (rightRd),
  .rightAddr(rightAddr),
  .rightBusy(rightBusy),
  .leftIrqN (leftIrqN),
  .rightIrqN(rightIrqN)
);

// File: tb/mbx_doorbell_top_tb.sv
module mbx_doorbell_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [16:0] TOP16 = 17'h0FFFF;
  localparam logic [16:0] LBX16 = 17'h0FFFE;
  localparam logic [16:0] TOP17 = 17'h1FFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lEn = 0, lWr = 0, lRd = 0, lBusy = 0;
  logic rEn = 0, rWr = 0, rRd = 0, rBusy = 0;
  logic [16:0] lAddr = '0, rAddr = '0;
  logic lIrqN, rIrqN, lIrqN17, rIrqN17;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_doorbell_top #(.ADDR_W(16)) u_dut (
    .clk(clk), .rstN(rstN),
    .leftEn(lEn), .leftWr(lWr), .leftRd(lRd), .leftAddr(lAddr[15:0]), .leftBusy(lBusy),
    .rightEn(rEn), .rightWr(rWr), .rightRd(rRd), .rightAddr(rAddr[15:0]), .rightBusy(rBusy),
    .leftIrqN(lIrqN), .rightIrqN(rIrqN)
  );

  mbx_doorbell_top #(.ADDR_W(17)) u_dut17 (
    .clk(clk), .rstN(rstN),
    .leftEn(lEn), .leftWr(lWr), .leftRd(lRd), .leftAddr(lAddr), .leftBusy(lBusy),
    .rightEn(rEn), .rightWr(rWr), .rightRd(rRd), .rightAddr(rAddr), .rightBusy(rBusy),
    .leftIrqN(lIrqN17), .rightIrqN(rIrqN17)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Called at a falling edge: apply one access per port, cross one rising
  // edge, return to the next falling edge with the ports idle.
  task automatic cyc(input logic le, input logic lw, input logic lr, input logic [16:0] la,
                     input logic lb, input logic re, input logic rw, input logic rr,
                     input logic [16:0] ra, input logic rb);
    lEn = le; lWr = lw; lRd = lr; lAddr = la; lBusy = lb;
    rEn = re; rWr = rw; rRd = rr; rAddr = ra; rBusy = rb;
    @(posedge clk);
    @(negedge clk);
    lEn = 0; lWr = 0; lRd = 0; lBusy = 0;
    rEn = 0; rWr = 0; rRd = 0; rBusy = 0;
  endtask

  task automatic idle();
    cyc(0, 0, 0, '0, 0, 0, 0, 0, '0, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "leftIrqN in reset", lIrqN, 1'b1);
    chk("R1", "rightIrqN in reset", rIrqN, 1'b1);
    rstN = 1'b1;
    idle();
    chk("R1", "leftIrqN after reset", lIrqN, 1'b1);
    chk("R1", "rightIrqN after reset", rIrqN, 1'b1);
  endtask

  task automatic t_right_exchange();
    cyc(1, 1, 0, TOP16, 0, 0, 0, 0, '0, 0);
    chk("R2", "rightIrqN after left ring", rIrqN, 1'b0);
    chk("R2", "leftIrqN untouched", lIrqN, 1'b1);
    cyc(1, 0, 1, TOP16, 0, 0, 0, 0, '0, 0);
    chk("R5", "left reading right box keeps flag", rIrqN, 1'b0);
    cyc(0, 0, 0, '0, 0, 1, 0, 1, TOP16, 0);
    chk("R4", "right own read clears", rIrqN, 1'b1);
  endtask

  task automatic t_left_exchange();
    cyc(0, 0, 0, '0, 0, 1, 1, 0, LBX16, 0);
    chk("R3", "leftIrqN after right ring", lIrqN, 1'b0);
    chk("R3", "rightIrqN untouched", rIrqN, 1'b1);
    cyc(0, 0, 0, '0, 0, 1, 0, 1, LBX16, 0);
    chk("R5", "right reading left box keeps flag", lIrqN, 1'b0);
    cyc(1, 1, 0, LBX16, 0, 0, 0, 0, '0, 0);
    chk("R5", "left writing own box keeps flag", lIrqN, 1'b0);
    cyc(1, 0, 1, LBX16, 0, 0, 0, 0, '0, 0);
    chk("R4", "left own read clears", lIrqN, 1'b1);
  endtask

  task automatic t_busy();
    cyc(1, 1, 0, TOP16, 1, 0, 0, 0, '0, 0);
    chk("R6", "busy left ring ignored", rIrqN, 1'b1);
    cyc(0, 0, 0, '0, 0, 1, 1, 0, LBX16, 1);
    chk("R6", "busy right ring ignored", lIrqN, 1'b1);
    cyc(1, 1, 0, TOP16, 0, 0, 0, 0, '0, 0);
    chk("R2", "ring after busy drops", rIrqN, 1'b0);
    cyc(0, 0, 0, '0, 0, 1, 0, 1, TOP16, 1);
    chk("R7", "busy own read keeps flag", rIrqN, 1'b0);
    cyc(0, 0, 0, '0, 0, 1, 0, 1, TOP16, 0);
    chk("R4", "own read clears after busy", rIrqN, 1'b1);
  endtask

  task automatic t_priority();
    cyc(1, 1, 0, TOP16, 0, 1, 0, 1, TOP16, 0);
    chk("R8", "set+clear from idle", rIrqN, 1'b0);
    cyc(1, 1, 0, TOP16, 0, 1, 0, 1, TOP16, 0);
    chk("R8", "set+clear while pending", rIrqN, 1'b0);
    cyc(0, 0, 0, '0, 0, 1, 0, 1, TOP16, 0);
    chk("R4", "clear after priority test", rIrqN, 1'b1);
  endtask

  task automatic t_ignore();
    cyc(0, 1, 0, TOP16, 0, 0, 1, 0, LBX16, 0);
    chk("R9", "disabled left ring", rIrqN, 1'b1);
    chk("R9", "disabled right ring", lIrqN, 1'b1);
    cyc(1, 1, 0, 17'h0FFFD, 0, 1, 1, 0, 17'h00000, 0);
    chk("R9", "other address left", rIrqN, 1'b1);
    chk("R9", "other address right", lIrqN, 1'b1);
    cyc(1, 1, 0, LBX16, 0, 0, 0, 0, '0, 0);
    chk("R5", "left own-box write no set", lIrqN, 1'b1);
  endtask

  task automatic t_rdwr();
    cyc(1, 1, 1, TOP16, 0, 0, 0, 0, '0, 0);
    chk("R10", "rd+wr ring still sets", rIrqN, 1'b0);
    cyc(0, 0, 0, '0, 0, 1, 1, 1, TOP16, 0);
    chk("R10", "rd+wr own box no clear", rIrqN, 1'b0);
    cyc(0, 0, 0, '0, 0, 1, 0, 1, TOP16, 0);
    chk("R4", "clear after rd+wr test", rIrqN, 1'b1);
  endtask

  task automatic t_width17();
    cyc(1, 1, 0, 17'h0FFFF, 0, 0, 0, 0, '0, 0);
    chk("R11", "17-bit ignores 0x0FFFF", rIrqN17, 1'b1);
    chk("R11", "16-bit rings on 0xFFFF", rIrqN, 1'b0);
    cyc(1, 1, 0, TOP17, 0, 0, 0, 0, '0, 0);
    chk("R11", "17-bit rings on 0x1FFFF", rIrqN17, 1'b0);
    cyc(0, 0, 0, '0, 0, 1, 1, 0, 17'h1FFFE, 0);
    chk("R11", "17-bit left box 0x1FFFE", lIrqN17, 1'b0);
    cyc(0, 0, 0, '0, 0, 1, 0, 1, TOP17, 0);
    chk("R11", "17-bit own read clears", rIrqN17, 1'b1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_right_exchange();
    t_left_exchange();
    t_busy();
    t_priority();
    t_ignore();
    t_rdwr();
    t_width17();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule